// File: doc/BRIEF.md
# Hardware Cursor Overlay Engine

This block paints a 32 by 32 pointer over an incoming pixel stream. Every beat of the stream carries one pixel together with the column and line counters of that pixel. Inside the active area, the block works out whether the pixel lies under the cursor box. If it does, the block fetches the 2-bit code for that cursor dot from a 256-byte bitmap. It then emits one of three things: the original pixel, a programmable colour, or the inverted pixel. Pixels outside the box, and pixels outside the active area, leave unchanged.

Software places the pointer by writing an insertion point and a hot-spot offset for each axis. The hot spot is the tip of the arrow, so the box's upper-left corner lands at insertion minus hot spot. Parts of the box that fall off any edge of the active area are clipped.

The bitmap can be filled in two ways. One is register writes. The other is an in-band upload from the pixel stream itself, taken on the line just before the first active line, immediately after the colour-table bytes that open that line.

Both stream sides use valid/ready. A beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A beat that is presented but not accepted must be held unchanged. The output keeps `out_valid` and `out_data` steady until `out_ready` takes it. The register port is a plain write strobe with no handshake.

Top module: `cursor_overlay`

## Requirements
- R1: Each accepted beat appears on the output exactly one cycle later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay stable.
- R2: After reset, `out_valid` is low and all configuration registers are zero, so the cursor is disabled and pixels pass through unchanged.
- R3: Cursor dot (row r, column c), with r and c in 0..31, takes its code from bitmap byte r*8 + c/4, in bits [2*(c%4)+1 : 2*(c%4)]. The lowest two bits hold the leftmost of the four dots. Row 0, column 0 is the upper-left dot.
- R4: A write with `reg_addr[8]`=1 stores `reg_wdata[7:0]` into bitmap byte `reg_addr[7:0]`. With `reg_addr[8]`=0, `reg_addr[3:0]` selects one register: 0 control (bit0 enable, bit1 code-3 colour select, bit2 in-band upload enable), 1 insertion X, 2 insertion Y, 3 hot-spot X (5 bits), 4 hot-spot Y (5 bits), 5 colour A, 6 colour B, 7 colour C, 8 first active line.
- R5: In screen coordinates (sx = column counter, sy = line counter minus first active line), the box's upper-left corner is at (insertion X - hot-spot X, insertion Y - hot-spot Y).
- R6: The active area is column < ACT_W together with first active line <= line < first active line + ACT_H. A pixel outside it, or outside the box, passes through unchanged, even when the corner is negative or the box crosses the right or bottom edge.
- R7: With control bit1 = 0, a pixel under the box maps as follows: code 0 gives the input pixel, code 1 gives colour A, code 2 gives colour B, and code 3 gives the bitwise inverse of the input pixel.
- R8: With control bit1 = 1, code 3 gives colour C. Codes 0 to 2 behave as in R7.
- R9: With control bit0 = 0, every pixel passes through unchanged.
- R10: With control bit2 = 1 and a non-zero first active line, an accepted beat on line (first active line - 1) at column LUT_BYTES + k, for k in 0..255, writes `in_data[7:0]` into bitmap byte k. If a register write to the same byte happens in the same cycle, the register write wins.
- R11: With control bit2 = 0, stream bytes on the upload line leave the bitmap untouched. Columns below LUT_BYTES never write the bitmap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register or bitmap byte address (R4) |
| reg_wdata | input | DATA_W | Register write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DATA_W | Input pixel |
| in_x | input | COORD_W | Column counter of the input pixel |
| in_y | input | COORD_W | Line counter of the input pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DATA_W | Mixed pixel |

## Verification
The bench builds the block with ACT_W=64, ACT_H=48, LUT_BYTES=16 and COORD_W=10. The small active area lets a few beats reach the right and bottom clipping edges. The short colour-table prefix means a full in-band upload line takes only 272 beats. DATA_W stays at 24, so the inversion and colour codes are checked on full-width pixels. The first active line is set to 4 at run time, so the upload line 3 and top-edge clipping are both in range.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM      = 32;
  localparam int CUR_LOG      = $clog2(CUR_DIM);
  localparam int CODE_W       = 2;
  localparam int PIX_PER_BYTE = 8 / CODE_W;
  localparam int SUB_W        = $clog2(PIX_PER_BYTE);
  localparam int CUR_BYTES    = CUR_DIM * CUR_DIM / PIX_PER_BYTE;
  localparam int BM_AW        = $clog2(CUR_BYTES);
  localparam int REG_AW       = BM_AW + 1;

  typedef enum logic [3:0] {
    RA_CTRL  = 4'd0,
    RA_INS_X = 4'd1,
    RA_INS_Y = 4'd2,
    RA_HOT_X = 4'd3,
    RA_HOT_Y = 4'd4,
    RA_COL_A = 4'd5,
    RA_COL_B = 4'd6,
    RA_COL_C = 4'd7,
    RA_FIRST = 4'd8
  } reg_sel_e;

  typedef struct packed {
    logic inband_en;
    logic c3_colour;
    logic enable;
  } ctrl_t;

  typedef enum logic [CODE_W-1:0] {
    CODE_CLEAR = 2'd0,
    CODE_A     = 2'd1,
    CODE_B     = 2'd2,
    CODE_X     = 2'd3
  } code_e;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int COORD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output ctrl_t               ctrl,
  output logic [COORD_W-1:0]  ins_x,
  output logic [COORD_W-1:0]  ins_y,
  output logic [CUR_LOG-1:0]  hot_x,
  output logic [CUR_LOG-1:0]  hot_y,
  output logic [DATA_W-1:0]   col_a,
  output logic [DATA_W-1:0]   col_b,
  output logic [DATA_W-1:0]   col_c,
  output logic [COORD_W-1:0]  first_line,
  output logic                bm_we,
  output logic [BM_AW-1:0]    bm_addr,
  output logic [7:0]          bm_data
);
  logic cfg_we;
  assign cfg_we  = reg_we && !reg_addr[REG_AW-1];
  assign bm_we   = reg_we && reg_addr[REG_AW-1];
  assign bm_addr = reg_addr[BM_AW-1:0];
  assign bm_data = reg_wdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      ins_x      <= '0;
      ins_y      <= '0;
      hot_x      <= '0;
      hot_y      <= '0;
      col_a      <= '0;
      col_b      <= '0;
      col_c      <= '0;
      first_line <= '0;
    end else if (cfg_we) begin
      case (reg_sel_e'(reg_addr[3:0]))
        RA_CTRL:  ctrl       <= ctrl_t'(reg_wdata[2:0]);
        RA_INS_X: ins_x      <= reg_wdata[COORD_W-1:0];
        RA_INS_Y: ins_y      <= reg_wdata[COORD_W-1:0];
        RA_HOT_X: hot_x      <= reg_wdata[CUR_LOG-1:0];
        RA_HOT_Y: hot_y      <= reg_wdata[CUR_LOG-1:0];
        RA_COL_A: col_a      <= reg_wdata;
        RA_COL_B: col_b      <= reg_wdata;
        RA_COL_C: col_c      <= reg_wdata;
        RA_FIRST: first_line <= reg_wdata[COORD_W-1:0];
        default:  ;
      endcase
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && reg_addr[3:0] == 4'd0 |=> ctrl == $past(reg_wdata[2:0])); // R4
endmodule

// File: rtl/cursor_bitmap.sv
module cursor_bitmap
  import cursor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_we,
  input  logic [BM_AW-1:0] a_addr,
  input  logic [7:0]       a_data,
  input  logic             b_we,
  input  logic [BM_AW-1:0] b_addr,
  input  logic [7:0]       b_data,
  input  logic [BM_AW-1:0] rd_addr,
  output logic [7:0]       rd_byte
);
  logic [7:0] mem [CUR_BYTES];
  logic       b_go;

  // register port has priority over in-band upload on a byte clash
  assign b_go = b_we && !(a_we && a_addr == b_addr);

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_data;
    if (b_go) mem[b_addr] <= b_data;
  end

  assign rd_byte = mem[rd_addr];

  AST_REG_BYTE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> mem[$past(a_addr)] == $past(a_data)); // R4
  AST_INBAND_BYTE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    b_we && !a_we |=> mem[$past(b_addr)] == $past(b_data)); // R10
endmodule

// File: rtl/cursor_locate.sv
module cursor_locate
  import cursor_pkg::*;
#(
  parameter int COORD_W   = 12,
  parameter int ACT_W     = 640,
  parameter int ACT_H     = 480,
  parameter int LUT_BYTES = 768
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [COORD_W-1:0]  in_x,
  input  logic [COORD_W-1:0]  in_y,
  input  logic [7:0]          in_byte,
  input  ctrl_t               ctrl,
  input  logic [COORD_W-1:0]  ins_x,
  input  logic [COORD_W-1:0]  ins_y,
  input  logic [CUR_LOG-1:0]  hot_x,
  input  logic [CUR_LOG-1:0]  hot_y,
  input  logic [COORD_W-1:0]  first_line,
  output logic [BM_AW-1:0]    rd_addr,
  input  logic [7:0]          rd_byte,
  output logic                hit,
  output logic [CODE_W-1:0]   code,
  output logic                up_we,
  output logic [BM_AW-1:0]    up_addr
);
  localparam int D_W = COORD_W + 2;
  localparam int O_W = COORD_W + 1;

  logic               act_x, act_y, in_box;
  logic [COORD_W-1:0] sy;
  logic [D_W-1:0]     dx, dy;
  logic [2*CUR_LOG-1:0] dot;
  logic [7:0]         shifted;

  assign act_x = {2'b00, in_x} < D_W'(ACT_W);
  assign act_y = (in_y >= first_line) &&
                 ({2'b00, in_y} < {2'b00, first_line} + D_W'(ACT_H));
  assign sy    = in_y - first_line;

  // offset of the pixel from the box corner (insertion - hot spot)
  assign dx = {2'b00, in_x} + D_W'(hot_x) - {2'b00, ins_x};
  assign dy = {2'b00, sy}   + D_W'(hot_y) - {2'b00, ins_y};
  assign in_box = (dx[D_W-1:CUR_LOG] == '0) && (dy[D_W-1:CUR_LOG] == '0);

  assign hit = ctrl.enable && act_x && act_y && in_box;

  assign dot     = {dy[CUR_LOG-1:0], dx[CUR_LOG-1:0]};
  assign rd_addr = dot[2*CUR_LOG-1:SUB_W];
  assign shifted = rd_byte >> {dot[SUB_W-1:0], 1'b0};
  assign code    = shifted[CODE_W-1:0];

  // in-band upload window on the line before the first active line
  logic          up_line, up_col;
  logic [O_W-1:0] off;
  assign up_line = (first_line != '0) && (in_y == first_line - 1'b1);
  assign off     = {1'b0, in_x} - O_W'(LUT_BYTES);
  assign up_col  = ({1'b0, in_x} >= O_W'(LUT_BYTES)) && (off[O_W-1:BM_AW] == '0);
  assign up_we   = accept && ctrl.inband_en && up_line && up_col;
  assign up_addr = off[BM_AW-1:0];

  AST_UPLOAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    up_we |-> ctrl.inband_en && !act_y); // R11
  AST_HIT_INSIDE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> in_x < COORD_W'(ACT_W) && in_y >= first_line); // R6
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              hit,
  input  logic [CODE_W-1:0] code,
  input  logic              c3_colour,
  input  logic [DATA_W-1:0] col_a,
  input  logic [DATA_W-1:0] col_b,
  input  logic [DATA_W-1:0] col_c,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] mixed;

  always_comb begin
    mixed = in_data;
    if (hit) begin
      case (code_e'(code))
        CODE_CLEAR: mixed = in_data;
        CODE_A:     mixed = col_a;
        CODE_B:     mixed = col_b;
        CODE_X:     mixed = c3_colour ? col_c : ~in_data;
        default:    mixed = in_data;
      endcase
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= mixed;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R1
  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_MISS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !hit |=> out_data == $past(in_data)); // R6
  AST_CLEAR_CODE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && hit && code == 2'd0 |=> out_data == $past(in_data)); // R7
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int COORD_W   = 12,
  parameter int ACT_W     = 640,
  parameter int ACT_H     = 480,
  parameter int LUT_BYTES = 768
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [8:0]         reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data
);
  ctrl_t               ctrl;
  logic [COORD_W-1:0]  ins_x, ins_y, first_line;
  logic [CUR_LOG-1:0]  hot_x, hot_y;
  logic [DATA_W-1:0]   col_a, col_b, col_c;
  logic                bm_we, up_we, hit;
  logic [BM_AW-1:0]    bm_addr, up_addr, rd_addr;
  logic [7:0]          bm_data, rd_byte;
  logic [CODE_W-1:0]   code;
  logic                accept;

  assign accept = in_valid && in_ready;

  cursor_regs #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr(reg_addr[REG_AW-1:0]), .reg_wdata,
    .ctrl, .ins_x, .ins_y, .hot_x, .hot_y, .col_a, .col_b, .col_c,
    .first_line, .bm_we, .bm_addr, .bm_data
  );

  cursor_bitmap u_bitmap (
    .clk, .rst_n,
    .a_we(bm_we), .a_addr(bm_addr), .a_data(bm_data),
    .b_we(up_we), .b_addr(up_addr), .b_data(in_data[7:0]),
    .rd_addr, .rd_byte
  );

  cursor_locate #(.COORD_W(COORD_W), .ACT_W(ACT_W), .ACT_H(ACT_H),
                  .LUT_BYTES(LUT_BYTES)) u_locate (
    .clk, .rst_n, .accept, .in_x, .in_y, .in_byte(in_data[7:0]), .ctrl,
    .ins_x, .ins_y, .hot_x, .hot_y, .first_line,
    .rd_addr, .rd_byte, .hit, .code, .up_we, .up_addr
  );

  cursor_mix #(.DATA_W(DATA_W)) u_mix (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .hit, .code,
    .c3_colour(ctrl.c3_colour), .col_a, .col_b, .col_c,
    .out_valid, .out_ready, .out_data
  );

  AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !ctrl.enable |=> out_data == $past(in_data)); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
endmodule

// File: tb/tb_cursor_overlay.sv
`timescale 1ns/1ps
module tb_cursor_overlay;
  localparam int DW = 24, CW = 10, AW = 64, AH = 48, LB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_x = '0, in_y = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  cursor_overlay #(.DATA_W(DW), .COORD_W(CW), .ACT_W(AW), .ACT_H(AH),
                   .LUT_BYTES(LB)) dut (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  int bm [256];
  int m_en = 0, m_c3 = 0, m_insx = 0, m_insy = 0, m_hotx = 0, m_hoty = 0, m_first = 0;
  localparam logic [DW-1:0] CA = 24'hF00001, CB = 24'h00F002, CC = 24'h0000F3;

  localparam int NV = 13;
  localparam int VX [NV] = '{17, 18, 19, 20, 48, 16, 49, 17, 17, 30, 33, 25, 70};
  localparam int VY [NV] = '{12, 12, 12, 12, 43, 12, 12, 11, 44, 20, 25, 12, 20};

  function automatic logic [DW-1:0] pd(int x, int y);
    return {x[7:0], y[7:0], 8'hA5};
  endfunction

  function automatic logic [DW-1:0] model(int x, int y, logic [DW-1:0] d);
    int c, r, code;
    if (m_en == 0 || x >= AW || y < m_first || y >= m_first + AH) return d;
    c = x - (m_insx - m_hotx);
    r = (y - m_first) - (m_insy - m_hoty);
    if (c < 0 || c > 31 || r < 0 || r > 31) return d;
    code = (bm[r*8 + c/4] >> (2*(c%4))) & 3;
    case (code)
      0: return d;
      1: return CA;
      2: return CB;
      default: return (m_c3 != 0) ? CC : ~d;
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[8:0]; reg_wdata = d[DW-1:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ctrl(int en, int c3, int ib);
    m_en = en; m_c3 = c3;
    wr(0, en | (c3 << 1) | (ib << 2));
  endtask

  // one beat; returns the output seen one cycle later (out_ready high)
  task automatic beat(int x, int y, logic [DW-1:0] d, output logic [DW-1:0] o);
    in_valid = 1'b1; in_x = x[CW-1:0]; in_y = y[CW-1:0]; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    o = out_data;
  endtask

  task automatic pix_check(string req, int x, int y);
    logic [DW-1:0] o;
    beat(x, y, pd(x, y), o);
    check(req, o, model(x, y, pd(x, y)));
  endtask

  task automatic walk(string req);
    for (int i = 0; i < NV; i++) pix_check(req, VX[i], VY[i]);
  endtask

  task automatic upload_line(int mul, int add);
    logic [DW-1:0] o;
    for (int x = 0; x < LB + 256; x++) begin
      int v;
      v = (x < LB) ? 8'hEE : (((x - LB) * mul + add) & 255);
      beat(x, m_first - 1, {16'h0, v[7:0]}, o);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] o, e1, e2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset state
    check("R2 out_valid", {23'h0, out_valid}, 24'h0);
    check("R2 in_ready", {23'h0, in_ready}, 24'h1);
    beat(17, 12, pd(17, 12), o);
    check("R2 disabled after reset", o, pd(17, 12));

    // R4: program registers and bitmap
    for (int k = 0; k < 256; k++) begin
      bm[k] = (k * 37 + 5) & 255;
      wr(256 + k, bm[k]);
    end
    m_first = 4; wr(8, 4);
    m_insx = 20; wr(1, 20);
    m_insy = 10; wr(2, 10);
    m_hotx = 3;  wr(3, 3);
    m_hoty = 2;  wr(4, 2);
    wr(5, CA); wr(6, CB); wr(7, CC);
    set_ctrl(1, 0, 0);

    // table walk: R3 packing, R5 placement, R6 edges, R7 code mapping
    walk("R3/R5/R6/R7 table");
    beat(25, 12, pd(25, 12), o);
    check("R7 code3 inverts", o, ~pd(25, 12));
    beat(17, 12, pd(17, 12), o);
    check("R4 colour A via byte0", o, CA);

    // R8: code 3 selects colour C
    set_ctrl(1, 1, 0);
    beat(25, 12, pd(25, 12), o);
    check("R8 code3 colour C", o, CC);

    // R9: disable forces pass-through
    set_ctrl(0, 1, 0);
    beat(17, 12, pd(17, 12), o);
    check("R9 disabled", o, pd(17, 12));
    beat(25, 12, pd(25, 12), o);
    check("R9 disabled code3", o, pd(25, 12));

    // R6: corner left of and above the active area (clipping)
    set_ctrl(1, 0, 0);
    m_insx = 1; wr(1, 1); m_hotx = 5; wr(3, 5);
    m_insy = 0; wr(2, 0); m_hoty = 31; wr(4, 31);
    beat(0, 4, pd(0, 4), o);
    check("R6 clip top-left", o, model(0, 4, pd(0, 4)));
    beat(3, 4, pd(3, 4), o);
    check("R6 clip top-left col3", o, model(3, 4, pd(3, 4)));
    // R6: box crossing the right edge
    m_insx = 60; wr(1, 60); m_hotx = 0; wr(3, 0);
    m_insy = 5; wr(2, 5); m_hoty = 0; wr(4, 0);
    pix_check("R6 right edge inside", 63, 9);
    beat(64, 9, pd(64, 9), o);
    check("R6 right edge clipped", o, pd(64, 9));
    beat(62, 52, pd(62, 52), o);
    check("R6 below active area", o, pd(62, 52));

    // back to the table placement
    m_insx = 20; wr(1, 20); m_insy = 10; wr(2, 10);
    m_hotx = 3; wr(3, 3); m_hoty = 2; wr(4, 2);

    // R10: in-band upload on line first-1
    set_ctrl(1, 0, 1);
    upload_line(11, 3);
    for (int k = 0; k < 256; k++) bm[k] = (k * 11 + 3) & 255;
    walk("R10 after in-band upload");

    // R11: upload disabled leaves the bitmap untouched
    set_ctrl(1, 0, 0);
    upload_line(5, 200);
    walk("R11 upload ignored");

    // R1: back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    e1 = model(18, 12, pd(18, 12));
    e2 = model(30, 20, pd(30, 20));
    in_valid = 1'b1; in_x = 18; in_y = 12; in_data = pd(18, 12);
    @(posedge clk); @(negedge clk);
    check("R1 first beat out", out_data, e1);
    in_x = 30; in_y = 20; in_data = pd(30, 20);
    check("R1 in_ready low on stall", {23'h0, in_ready}, 24'h0);
    @(posedge clk); @(negedge clk);
    check("R1 data held", out_data, e1);
    check("R1 valid held", {23'h0, out_valid}, 24'h1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R1 second beat out", out_data, e2);
    @(posedge clk); @(negedge clk);
    check("R1 drains", {23'h0, out_valid}, 24'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule